// File: doc/BRIEF.md
# Console Address Decoder with Boot Overlay

This block sits between an 8-bit CPU and the memories and peripherals of a small console. It splits a 16-bit address space into cartridge, video memory, work RAM, sprite attribute memory, I/O and high RAM. For every access it raises exactly one region select, forms the physical work RAM address and steers the addressed region's read data back to the CPU. All decoding is combinational from the address. The block owns two small registers: a boot-disable flag and a work RAM bank number.

A start-up program is overlaid on the low cartridge area while the boot flag is active. The overlay covers only reads: one window in both console modes and a second window in colour mode only. Cartridge header addresses between the two windows always reach the cartridge. The upper half of work RAM is banked in colour mode, and bank number zero is promoted to one. A mirror of work RAM above it ignores the bank register. Unusable and unpopulated addresses read as all ones and raise no select.

Top module: `mmap_decoder`

## Requirements
- R1: After synchronous reset the boot overlay is active and the work RAM bank is 1: a colour-mode read of 0xFF50 returns 0x00, a read of 0xFF70 returns 0xF9, and 0xD123 maps to physical 0x1123.
- R2: While boot is active, reads of 0x0000-0x00FF select the boot ROM (region_sel bit 6). In colour mode reads of 0x0200-0x08FF also select it. Reads of 0x0100-0x01FF, and reads of 0x0200-0x08FF in monochrome mode, select the cartridge. Writes to any of these addresses always select the cartridge.
- R3: A write of a nonzero value to 0xFF50 turns the boot overlay off until the next reset. A write of 0x00 changes nothing. A read of 0xFF50 returns 0x01 when the overlay is off and 0x00 when it is on.
- R4: Addresses 0xC000-0xCFFF map to physical work RAM address (address & 0x0FFF) whatever the bank.
- R5: Addresses 0xD000-0xDFFF map to physical address bank*0x1000 + (address & 0x0FFF), where bank is the bank register in colour mode and 1 in monochrome mode.
- R6: In colour mode a write to 0xFF70 stores data bits 2..0 as the bank, with 0 stored as 1. A read returns the bank in bits 2..0 with bits 7..3 all ones.
- R7: In monochrome mode 0xFF70 reads as 0xFF, writes to it leave the register unchanged, and the banked window uses bank 1.
- R8: Addresses 0xE000-0xFDFF map to physical address (address & 0x1FFF), independent of the bank register.
- R9: Reads of 0xFEA0-0xFEFF, 0xFF56 and every I/O address in 0xFF00-0xFF7F not listed in R10 return 0xFF, and accesses to them raise no select.
- R10: region_sel bits are: 0 cartridge (0x0000-0x7FFF, 0xA000-0xBFFF), 1 video (0x8000-0x9FFF), 2 work RAM (0xC000-0xFDFF), 3 sprite memory (0xFE00-0xFE9F), 4 I/O (0xFF00-0xFF02, 0xFF04-0xFF07, 0xFF0F, 0xFF10-0xFF26, 0xFF30-0xFF3F, 0xFF40-0xFF4D, 0xFF4F, 0xFF51-0xFF55, 0xFF68-0xFF6B, 0xFFFF), 5 high RAM (0xFF80-0xFFFE), 6 boot ROM. A select is high only while a read or write strobe is high, and at most one is high. 0xFF50 and 0xFF70 raise no select.
- R11: cpu_rdata equals the read data input of the region that a read of the current address selects, or the internal register value for 0xFF50 and 0xFF70.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| color_mode | input | 1 | 1 for colour mode, 0 for monochrome mode |
| boot_rdata | input | 8 | Boot ROM read data |
| cart_rdata | input | 8 | Cartridge read data |
| vram_rdata | input | 8 | Video memory read data |
| wram_rdata | input | 8 | Work RAM read data |
| oam_rdata | input | 8 | Sprite attribute memory read data |
| io_rdata | input | 8 | Peripheral register read data |
| hram_rdata | input | 8 | High RAM read data |
| region_sel | output | 7 | Region selects, bit assignment in R10 |
| wram_addr | output | 15 | Physical work RAM address |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
The bench goes after the edges of the overlay windows (0x00FF, 0x0100, 0x01FF, 0x0200, 0x08FF, 0x0900) in both modes; a decoder that mixed them up would hand header bytes from the boot ROM or run cartridge code during start-up. It writes bank value 0 and values whose low bits are 0, where a design without the promotion would alias the banked window onto the fixed one. It checks that the mirror region keeps its mapping after bank changes, that monochrome writes to the bank register are dropped, and that a zero write after disabling boot does not bring the overlay back. Random traffic in both modes is compared with a bench model of the map so that gaps in the I/O list show up as wrong selects or data that is not all ones.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    localparam int CPU_AW = 16;
    localparam int CPU_DW = 8;
    localparam int PAGE_W = 12;

    // Region boundaries (last address of each window)
    localparam logic [CPU_AW-1:0] CART_LO_END   = 16'h7FFF;
    localparam logic [CPU_AW-1:0] VRAM_END      = 16'h9FFF;
    localparam logic [CPU_AW-1:0] CART_RAM_END  = 16'hBFFF;
    localparam logic [CPU_AW-1:0] WRAM_END      = 16'hFDFF;
    localparam logic [CPU_AW-1:0] OAM_END       = 16'hFE9F;
    localparam logic [CPU_AW-1:0] DEAD_END      = 16'hFEFF;
    localparam logic [CPU_AW-1:0] HRAM_START    = 16'hFF80;
    localparam logic [CPU_AW-1:0] HRAM_END      = 16'hFFFE;

    // Boot overlay windows
    localparam logic [CPU_AW-1:0] BOOT_LO_END   = 16'h00FF;
    localparam logic [CPU_AW-1:0] BOOT_HI_START = 16'h0200;
    localparam logic [CPU_AW-1:0] BOOT_HI_END   = 16'h08FF;

    // Registers held inside the decoder
    localparam logic [CPU_AW-1:0] BOOTCTL_ADDR  = 16'hFF50;
    localparam logic [CPU_AW-1:0] BANKCTL_ADDR  = 16'hFF70;

    // Select bit positions
    localparam int SEL_CART = 0;
    localparam int SEL_VRAM = 1;
    localparam int SEL_WRAM = 2;
    localparam int SEL_OAM  = 3;
    localparam int SEL_IO   = 4;
    localparam int SEL_HRAM = 5;
    localparam int SEL_BOOT = 6;
    localparam int SEL_N    = 7;

    typedef enum logic [3:0] {
        RG_OPEN,
        RG_BOOT,
        RG_CART,
        RG_VRAM,
        RG_WRAM,
        RG_OAM,
        RG_IO,
        RG_HRAM,
        RG_BOOTCTL,
        RG_BANKCTL
    } region_e;

    // Read view (overlay applied) and write view (overlay ignored)
    typedef struct packed {
        region_e rd;
        region_e wr;
    } route_t;

    function automatic region_e sel_region(input int idx);
        case (idx)
            SEL_CART: return RG_CART;
            SEL_VRAM: return RG_VRAM;
            SEL_WRAM: return RG_WRAM;
            SEL_OAM:  return RG_OAM;
            SEL_IO:   return RG_IO;
            SEL_HRAM: return RG_HRAM;
            default:  return RG_BOOT;
        endcase
    endfunction

    // Populated peripheral registers in page 0xFF (low byte)
    function automatic logic io_present(input logic [7:0] lo);
        return lo inside {[8'h00:8'h02], [8'h04:8'h07], 8'h0F,
                          [8'h10:8'h26], [8'h30:8'h3F], [8'h40:8'h4D],
                          8'h4F, [8'h51:8'h55], [8'h68:8'h6B], 8'hFF};
    endfunction

endpackage

// File: rtl/mmap_region_decode.sv
module mmap_region_decode
    import mmap_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    input  logic              boot_on,
    input  logic              color_mode,
    output route_t            route
);

    region_e base;
    logic    in_lo_win;
    logic    in_hi_win;
    logic    overlay;

    always_comb begin
        if (addr <= CART_LO_END)
            base = RG_CART;
        else if (addr <= VRAM_END)
            base = RG_VRAM;
        else if (addr <= CART_RAM_END)
            base = RG_CART;
        else if (addr <= WRAM_END)
            base = RG_WRAM;
        else if (addr <= OAM_END)
            base = RG_OAM;
        else if (addr <= DEAD_END)
            base = RG_OPEN;
        else if (addr == BOOTCTL_ADDR)
            base = RG_BOOTCTL;
        else if (addr == BANKCTL_ADDR)
            base = RG_BANKCTL;
        else if (addr >= HRAM_START && addr <= HRAM_END)
            base = RG_HRAM;
        else if (io_present(addr[7:0]))
            base = RG_IO;
        else
            base = RG_OPEN;
    end

    assign in_lo_win = (addr <= BOOT_LO_END);
    assign in_hi_win = (addr >= BOOT_HI_START) && (addr <= BOOT_HI_END);
    assign overlay   = boot_on && (in_lo_win || (color_mode && in_hi_win));

    assign route.rd = overlay ? RG_BOOT : base;
    assign route.wr = base;

endmodule

// File: rtl/mmap_ctrl_regs.sv
module mmap_ctrl_regs
    import mmap_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_boot,
    input  logic              wr_bank,
    input  logic              color_mode,
    input  logic [CPU_DW-1:0] wdata,
    output logic              boot_on,
    output logic [BANK_W-1:0] bank_q
);

    localparam logic [BANK_W-1:0] BANK_DEFAULT = BANK_W'(1);

    logic [BANK_W-1:0] bank_in;

    assign bank_in = (wdata[BANK_W-1:0] == '0) ? BANK_DEFAULT : wdata[BANK_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            boot_on <= 1'b1;
            bank_q  <= BANK_DEFAULT;
        end else begin
            // Disabling is one-way: zero writes never re-arm the overlay
            if (wr_boot && (wdata != '0))
                boot_on <= 1'b0;
            if (wr_bank && color_mode)
                bank_q <= bank_in;
        end
    end

endmodule

// File: rtl/mmap_wram_map.sv
module mmap_wram_map
    import mmap_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic [CPU_AW-1:0]        addr,
    input  logic [BANK_W-1:0]        bank,
    output logic [BANK_W+PAGE_W-1:0] phys
);

    localparam int AW = BANK_W + PAGE_W;

    always_comb begin
        case (addr[CPU_AW-1:PAGE_W])
            4'hC:    phys = AW'(addr[PAGE_W-1:0]);
            4'hD:    phys = {bank, addr[PAGE_W-1:0]};
            default: phys = AW'(addr[PAGE_W:0]);
        endcase
    end

endmodule

// File: rtl/mmap_rdata_mux.sv
module mmap_rdata_mux
    import mmap_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  region_e           rd_region,
    input  logic              boot_on,
    input  logic              color_mode,
    input  logic [BANK_W-1:0] bank_q,
    input  logic [CPU_DW-1:0] boot_rdata,
    input  logic [CPU_DW-1:0] cart_rdata,
    input  logic [CPU_DW-1:0] vram_rdata,
    input  logic [CPU_DW-1:0] wram_rdata,
    input  logic [CPU_DW-1:0] oam_rdata,
    input  logic [CPU_DW-1:0] io_rdata,
    input  logic [CPU_DW-1:0] hram_rdata,
    output logic [CPU_DW-1:0] rdata
);

    localparam int PAD_W = CPU_DW - BANK_W;

    logic [CPU_DW-1:0] bank_view;

    assign bank_view = color_mode ? {{PAD_W{1'b1}}, bank_q} : '1;

    always_comb begin
        case (rd_region)
            RG_BOOT:    rdata = boot_rdata;
            RG_CART:    rdata = cart_rdata;
            RG_VRAM:    rdata = vram_rdata;
            RG_WRAM:    rdata = wram_rdata;
            RG_OAM:     rdata = oam_rdata;
            RG_IO:      rdata = io_rdata;
            RG_HRAM:    rdata = hram_rdata;
            RG_BOOTCTL: rdata = CPU_DW'(!boot_on);
            RG_BANKCTL: rdata = bank_view;
            default:    rdata = '1;
        endcase
    end

endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CPU_AW-1:0]        cpu_addr,
    input  logic [CPU_DW-1:0]        cpu_wdata,
    input  logic                     cpu_rd,
    input  logic                     cpu_wr,
    input  logic                     color_mode,
    input  logic [CPU_DW-1:0]        boot_rdata,
    input  logic [CPU_DW-1:0]        cart_rdata,
    input  logic [CPU_DW-1:0]        vram_rdata,
    input  logic [CPU_DW-1:0]        wram_rdata,
    input  logic [CPU_DW-1:0]        oam_rdata,
    input  logic [CPU_DW-1:0]        io_rdata,
    input  logic [CPU_DW-1:0]        hram_rdata,
    output logic [SEL_N-1:0]         region_sel,
    output logic [BANK_W+PAGE_W-1:0] wram_addr,
    output logic [CPU_DW-1:0]        cpu_rdata
);

    localparam logic [BANK_W-1:0] MONO_BANK = BANK_W'(1);

    route_t            route;
    logic              boot_on;
    logic [BANK_W-1:0] bank_q;
    logic [BANK_W-1:0] bank_eff;
    logic              wr_boot;
    logic              wr_bank;

    mmap_region_decode u_decode (
        .addr       (cpu_addr),
        .boot_on    (boot_on),
        .color_mode (color_mode),
        .route      (route)
    );

    assign wr_boot = cpu_wr && (route.wr == RG_BOOTCTL);
    assign wr_bank = cpu_wr && (route.wr == RG_BANKCTL);

    mmap_ctrl_regs #(.BANK_W(BANK_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_boot    (wr_boot),
        .wr_bank    (wr_bank),
        .color_mode (color_mode),
        .wdata      (cpu_wdata),
        .boot_on    (boot_on),
        .bank_q     (bank_q)
    );

    assign bank_eff = color_mode ? bank_q : MONO_BANK;

    mmap_wram_map #(.BANK_W(BANK_W)) u_wmap (
        .addr (cpu_addr),
        .bank (bank_eff),
        .phys (wram_addr)
    );

    mmap_rdata_mux #(.BANK_W(BANK_W)) u_rmux (
        .rd_region  (route.rd),
        .boot_on    (boot_on),
        .color_mode (color_mode),
        .bank_q     (bank_q),
        .boot_rdata (boot_rdata),
        .cart_rdata (cart_rdata),
        .vram_rdata (vram_rdata),
        .wram_rdata (wram_rdata),
        .oam_rdata  (oam_rdata),
        .io_rdata   (io_rdata),
        .hram_rdata (hram_rdata),
        .rdata      (cpu_rdata)
    );

    for (genvar i = 0; i < SEL_N; i++) begin : g_sel
        assign region_sel[i] = (cpu_rd && (route.rd == sel_region(i)))
                            || (cpu_wr && (route.wr == sel_region(i)));
    end

endmodule

// File: rtl/mmap_decoder_chk.sv
module mmap_decoder_chk
    import mmap_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic [CPU_AW-1:0]        cpu_addr,
    input logic [CPU_DW-1:0]        cpu_wdata,
    input logic                     cpu_rd,
    input logic                     cpu_wr,
    input logic                     color_mode,
    input logic [SEL_N-1:0]         region_sel,
    input logic [BANK_W+PAGE_W-1:0] wram_addr,
    input logic [CPU_DW-1:0]        cpu_rdata,
    input logic                     boot_on,
    input logic [BANK_W-1:0]        bank_q
);

    localparam int AW = BANK_W + PAGE_W;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(region_sel)); // R10

    AST_SEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rd && !cpu_wr) |-> (region_sel == '0)); // R10

    AST_BOOT_STICKY: assert property (@(posedge clk) disable iff (rst)
        !boot_on |=> !boot_on); // R3

    AST_BOOT_GAP_CART: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && cpu_addr[15:8] == 8'h01) |-> (region_sel[SEL_CART] && !region_sel[SEL_BOOT])); // R2

    AST_BANK_ZERO_PROMOTE: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && color_mode && cpu_addr == BANKCTL_ADDR && cpu_wdata[BANK_W-1:0] == '0)
        |=> (bank_q == BANK_W'(1))); // R6

    AST_MONO_BANK_HELD: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !color_mode && cpu_addr == BANKCTL_ADDR) |=> $stable(bank_q)); // R7

    AST_ECHO_UNBANKED: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr >= 16'hE000 && cpu_addr <= WRAM_END) |-> (wram_addr == AW'(cpu_addr[12:0]))); // R8

    AST_DEAD_READS_ONES: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && cpu_addr > OAM_END && cpu_addr <= DEAD_END)
        |-> (cpu_rdata == '1 && region_sel == '0)); // R9

endmodule

bind mmap_decoder mmap_decoder_chk #(.BANK_W(BANK_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .color_mode (color_mode),
    .region_sel (region_sel),
    .wram_addr  (wram_addr),
    .cpu_rdata  (cpu_rdata),
    .boot_on    (boot_on),
    .bank_q     (bank_q)
);

// File: tb/mmap_decoder_tb.sv
module mmap_decoder_tb;

    localparam logic [7:0] D_BOOT = 8'hB1;
    localparam logic [7:0] D_CART = 8'hC2;
    localparam logic [7:0] D_VRAM = 8'h93;
    localparam logic [7:0] D_WRAM = 8'h74;
    localparam logic [7:0] D_OAM  = 8'h65;
    localparam logic [7:0] D_IO   = 8'h56;
    localparam logic [7:0] D_HRAM = 8'h47;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        color_mode = 1'b1;
    logic [6:0]  region_sel;
    logic [14:0] wram_addr;
    logic [7:0]  cpu_rdata;

    int n_checks = 0;
    int n_errors = 0;

    // bench model state
    bit       m_boot = 1'b1;
    bit [2:0] m_bank = 3'd1;

    logic [6:0]  obs_sel;
    logic [7:0]  obs_rdata;
    logic [14:0] obs_waddr;

    always #2 clk = ~clk;

    mmap_decoder u_dut (
        .clk        (clk),
        .rst        (rst),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .color_mode (color_mode),
        .boot_rdata (D_BOOT),
        .cart_rdata (D_CART),
        .vram_rdata (D_VRAM),
        .wram_rdata (D_WRAM),
        .oam_rdata  (D_OAM),
        .io_rdata   (D_IO),
        .hram_rdata (D_HRAM),
        .region_sel (region_sel),
        .wram_addr  (wram_addr),
        .cpu_rdata  (cpu_rdata)
    );

    function automatic bit is_io(input logic [7:0] lo);
        case (lo) inside
            [8'h00:8'h02], [8'h04:8'h07], 8'h0F, [8'h10:8'h26], [8'h30:8'h3F],
            [8'h40:8'h4D], 8'h4F, [8'h51:8'h55], [8'h68:8'h6B], 8'hFF: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // -1 none, 0..6 select bit, 7 boot register, 8 bank register
    function automatic int target(input logic [15:0] a, input bit rd_view, input bit boot, input bit col);
        if (rd_view && boot && (a <= 16'h00FF || (col && a >= 16'h0200 && a <= 16'h08FF))) return 6;
        if (a <= 16'h7FFF) return 0;
        if (a <= 16'h9FFF) return 1;
        if (a <= 16'hBFFF) return 0;
        if (a <= 16'hFDFF) return 2;
        if (a <= 16'hFE9F) return 3;
        if (a <= 16'hFEFF) return -1;
        if (a == 16'hFF50) return 7;
        if (a == 16'hFF70) return 8;
        if (a >= 16'hFF80 && a <= 16'hFFFE) return 5;
        if (is_io(a[7:0])) return 4;
        return -1;
    endfunction

    function automatic logic [6:0] exp_sel(input logic [15:0] a, input bit rd, input bit wr);
        logic [6:0] s = '0;
        int tr = target(a, 1'b1, m_boot, color_mode);
        int tw = target(a, 1'b0, m_boot, color_mode);
        if (rd && tr >= 0 && tr <= 6) s[tr] = 1'b1;
        if (wr && tw >= 0 && tw <= 6) s[tw] = 1'b1;
        return s;
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [15:0] a);
        case (target(a, 1'b1, m_boot, color_mode))
            0: return D_CART;
            1: return D_VRAM;
            2: return D_WRAM;
            3: return D_OAM;
            4: return D_IO;
            5: return D_HRAM;
            6: return D_BOOT;
            7: return {7'b0, !m_boot};
            8: return color_mode ? {5'h1F, m_bank} : 8'hFF;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [14:0] exp_waddr(input logic [15:0] a);
        bit [2:0] b = color_mode ? m_bank : 3'd1;
        if (a[15:12] == 4'hC) return {3'b0, a[11:0]};
        if (a[15:12] == 4'hD) return {b, a[11:0]};
        return {2'b0, a[12:0]};
    endfunction

    function automatic string tag_of(input logic [15:0] a);
        if (a <= 16'h08FF) return "R2";
        if (a[15:12] == 4'hC) return "R4";
        if (a[15:12] == 4'hD) return "R5";
        if (a >= 16'hE000 && a <= 16'hFDFF) return "R8";
        if (a == 16'hFF50) return "R3";
        if (a == 16'hFF70) return color_mode ? "R6" : "R7";
        if (target(a, 1'b1, m_boot, color_mode) < 0) return "R9";
        return "R11";
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    // One bus cycle: drive at falling edge, check mid-low phase, commit at rising edge
    task automatic step(input logic [15:0] a, input logic [7:0] d, input bit rd, input bit wr);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr;
        #1;
        obs_sel = region_sel; obs_rdata = cpu_rdata; obs_waddr = wram_addr;
        chk(tag_of(a), "select", 32'(obs_sel), 32'(exp_sel(a, rd, wr)));
        if (rd) chk(tag_of(a), "read data", 32'(obs_rdata), 32'(exp_rdata(a)));
        if (a >= 16'hC000 && a <= 16'hFDFF)
            chk(tag_of(a), "wram address", 32'(obs_waddr), 32'(exp_waddr(a)));
        @(posedge clk);
        if (wr && a == 16'hFF50 && d != 8'h00) m_boot = 1'b0;
        if (wr && a == 16'hFF70 && color_mode) m_bank = (d[2:0] == 3'd0) ? 3'd1 : d[2:0];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cpu_rd = 1'b0; cpu_wr = 1'b0;
        repeat (3) @(posedge clk);
        m_boot = 1'b1; m_bank = 3'd1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic random_phase(input int count);
        for (int i = 0; i < count; i++) begin
            logic [15:0] a;
            int cls = $urandom % 4;
            int op  = $urandom % 4;
            case (cls)
                0: a = 16'($urandom);
                1: a = 16'($urandom % 16'h0A00);
                2: a = 16'hC000 + 16'($urandom % 16'h4000);
                default: a = 16'hFF00 | 16'($urandom % 256);
            endcase
            step(a, 8'($urandom), op == 1 || op == 2, op == 3);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        color_mode = 1'b1;
        do_reset();

        // R1: reset state in colour mode
        step(16'hFF50, 8'h00, 1, 0); chk("R1", "boot reg after reset", 32'(obs_rdata), 32'h00);
        step(16'hFF70, 8'h00, 1, 0); chk("R1", "bank reg after reset", 32'(obs_rdata), 32'hF9);
        step(16'hD123, 8'h00, 1, 0); chk("R1", "banked map after reset", 32'(obs_waddr), 32'h1123);

        // R2: overlay window edges in colour mode
        step(16'h0050, 8'h00, 1, 0); chk("R2", "boot low window", 32'(obs_rdata), 32'(D_BOOT));
        step(16'h00FF, 8'h00, 1, 0); chk("R2", "boot low edge", 32'(obs_sel), 32'h40);
        step(16'h0100, 8'h00, 1, 0); chk("R2", "gap start to cart", 32'(obs_rdata), 32'(D_CART));
        step(16'h01FF, 8'h00, 1, 0); chk("R2", "gap end to cart", 32'(obs_sel), 32'h01);
        step(16'h0200, 8'h00, 1, 0); chk("R2", "colour high window", 32'(obs_rdata), 32'(D_BOOT));
        step(16'h08FF, 8'h00, 1, 0); chk("R2", "colour high edge", 32'(obs_sel), 32'h40);
        step(16'h0900, 8'h00, 1, 0); chk("R2", "past high window", 32'(obs_sel), 32'h01);
        step(16'h0050, 8'h3C, 0, 1); chk("R2", "overlay write to cart", 32'(obs_sel), 32'h01);

        // R11: data mux per region
        step(16'h8123, 8'h00, 1, 0); chk("R11", "video data", 32'(obs_rdata), 32'(D_VRAM));
        step(16'hFE10, 8'h00, 1, 0); chk("R11", "sprite data", 32'(obs_rdata), 32'(D_OAM));
        step(16'hFF40, 8'h00, 1, 0); chk("R11", "io data", 32'(obs_rdata), 32'(D_IO));
        step(16'hFF90, 8'h00, 1, 0); chk("R11", "high ram data", 32'(obs_rdata), 32'(D_HRAM));
        step(16'hFFFF, 8'h00, 0, 1); chk("R10", "top io select", 32'(obs_sel), 32'h10);
        step(16'h5000, 8'h00, 0, 0); chk("R10", "idle no select", 32'(obs_sel), 32'h00);

        // R6: bank register
        step(16'hFF70, 8'h05, 0, 1); chk("R6", "bank write no select", 32'(obs_sel), 32'h00);
        step(16'hFF70, 8'h00, 1, 0); chk("R6", "bank readback 5", 32'(obs_rdata), 32'hFD);
        step(16'hD010, 8'h00, 1, 0); chk("R5", "bank 5 map", 32'(obs_waddr), 32'h5010);
        step(16'hFF70, 8'h08, 0, 1);
        step(16'hFF70, 8'h00, 1, 0); chk("R6", "zero low bits give bank 1", 32'(obs_rdata), 32'hF9);
        step(16'hFF70, 8'h00, 0, 1);
        step(16'hDFFF, 8'h00, 1, 0); chk("R6", "bank 0 maps to 1", 32'(obs_waddr), 32'h1FFF);
        step(16'hFF70, 8'hFF, 0, 1);
        step(16'hFF70, 8'h00, 1, 0); chk("R6", "bank readback 7", 32'(obs_rdata), 32'hFF);

        // R8 and R4 with bank 7
        step(16'hE123, 8'h00, 1, 0); chk("R8", "mirror low", 32'(obs_waddr), 32'h0123);
        step(16'hF456, 8'h00, 1, 0); chk("R8", "mirror high unbanked", 32'(obs_waddr), 32'h1456);
        step(16'hCABC, 8'h00, 1, 0); chk("R4", "fixed window", 32'(obs_waddr), 32'h0ABC);

        // R9: all-ones areas
        step(16'hFEA0, 8'h00, 1, 0); chk("R9", "dead start", 32'(obs_rdata), 32'hFF);
        step(16'hFEFF, 8'h00, 1, 0); chk("R9", "dead end sel", 32'(obs_sel), 32'h00);
        step(16'hFF56, 8'h00, 1, 0); chk("R9", "infrared port", 32'(obs_rdata), 32'hFF);
        step(16'hFF03, 8'h00, 1, 0); chk("R9", "unmapped io", 32'(obs_rdata), 32'hFF);
        step(16'hFF56, 8'h12, 0, 1); chk("R9", "infrared write no select", 32'(obs_sel), 32'h00);

        random_phase(2500);

        // R3: boot disable, sticky
        do_reset();
        step(16'hFF50, 8'h00, 0, 1);
        step(16'h0010, 8'h00, 1, 0); chk("R3", "zero write keeps boot", 32'(obs_rdata), 32'(D_BOOT));
        step(16'hFF50, 8'h11, 0, 1);
        step(16'hFF50, 8'h00, 1, 0); chk("R3", "boot reg reads 1", 32'(obs_rdata), 32'h01);
        step(16'h0010, 8'h00, 1, 0); chk("R3", "overlay gone", 32'(obs_rdata), 32'(D_CART));
        step(16'hFF50, 8'h00, 0, 1);
        step(16'hFF50, 8'h00, 1, 0); chk("R3", "zero write does not re-arm", 32'(obs_rdata), 32'h01);

        // Monochrome mode
        color_mode = 1'b0;
        do_reset();
        step(16'hFF70, 8'h00, 1, 0); chk("R7", "mono bank read", 32'(obs_rdata), 32'hFF);
        step(16'hFF70, 8'h05, 0, 1);
        step(16'hD010, 8'h00, 1, 0); chk("R7", "mono bank fixed", 32'(obs_waddr), 32'h1010);
        step(16'h0300, 8'h00, 1, 0); chk("R2", "mono high window to cart", 32'(obs_rdata), 32'(D_CART));
        step(16'h00A0, 8'h00, 1, 0); chk("R2", "mono low window", 32'(obs_rdata), 32'(D_BOOT));
        color_mode = 1'b1;
        step(16'hFF70, 8'h00, 1, 0); chk("R7", "mono write left bank 1", 32'(obs_rdata), 32'hF9);
        color_mode = 1'b0;
        random_phase(2500);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule